// File: doc/BRIEF.md
# Connectivity Test Tree

This block gives a board tester a way to confirm that every digital input pin of the device is soldered and reachable. When reset ends it reads a strap input once and keeps what it read. A low strap leaves the device in normal mode: a multi-function output pin carries its usual signal, which arrives on `func_i`. A high strap latches a test mode. The pin then shows the output of a serial chain of two-input NAND stages that spans the serial data input, the serial clock input and four voltage-ID inputs.

For the test, the tester first drives all six chain inputs low. It then raises them one at a time and keeps each one high, in order from the input nearest the output to the farthest input. The pin changes level at every step. The chain is combinational, so the pin follows the inputs within the same cycle. Only the mode is held in a register.

Top module: `conn_test_tree`

## Requirements
- R1: While `rst_ni` is low, `test_mode_o` is 0 and `pin_o` equals `func_i`.
- R2: On the first rising clock edge after `rst_ni` goes high, `strap_i` is sampled, and `test_mode_o` takes the sampled value right after that edge.
- R3: Changes on `strap_i` after that first sampling edge have no effect on `test_mode_o`.
- R4: The latched mode changes only through reset. Asserting `rst_ni` low clears test mode to 0 at once.
- R5: When `test_mode_o` is 0, `pin_o` equals `func_i` in every cycle.
- R6: When `test_mode_o` is 1, `pin_o` does not depend on `func_i`.
- R7: In test mode, with all six chain inputs low, `pin_o` is 1.
- R8: In test mode, a walking-one sequence toggles `pin_o` at every step. The sequence raises `sda_i`, then `scl_i`, then `vid_i[0]` through `vid_i[3]`, each kept high.
- R9: In test mode, `pin_o` equals the chain value. Chain position 0 is `sda_i`, position 1 is `scl_i`, and positions 2 to 5 are `vid_i[0]` to `vid_i[3]`. Stage 5 is NOT of position 5. Each stage k below 5 is NAND(position k, stage k+1). `pin_o` is stage 0. With all inputs high, `pin_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 1 | Mode strap, sampled once after reset |
| sda_i | input | 1 | Serial data input, chain position 0 |
| scl_i | input | 1 | Serial clock input, chain position 1 |
| vid_i | input | 4 | Voltage-ID inputs, chain positions 2 to 5 |
| func_i | input | 1 | Normal-mode function of the shared pin |
| pin_o | output | 1 | Shared multi-function pin |
| test_mode_o | output | 1 | Latched test-mode flag |

## Verification
Some properties are checked on every cycle by assertions. These are: the one-time sampling of the strap, the mode holding steady once it has been sampled, the pin following `func_i` in normal mode, the pin holding steady against `func_i` in test mode, and the all-low and all-high chain values.

Other properties only show up in the bench's scenarios, which compare the pin against a behavioural chain model on every clock. These are: the toggle at each step of the walking-one sequence, the chain order for arbitrary input patterns, the strap being ignored after sampling, and the mode clearing when reset is asserted again.

// File: rtl/conn_test_pkg.sv
package conn_test_pkg;
  localparam int unsigned VID_W   = 4;
  localparam int unsigned TREE_W  = VID_W + 2;
  localparam int unsigned POS_SDA = 0;
  localparam int unsigned POS_SCL = 1;
  localparam int unsigned POS_VID = 2;
endpackage

// File: rtl/conn_strap_latch.sv
module conn_strap_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  output logic mode_o
);
  logic sampled_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sampled_q <= 1'b0;
      mode_q    <= 1'b0;
    end else if (!sampled_q) begin
      sampled_q <= 1'b1;
      mode_q    <= strap_i;
    end
  end

  assign mode_o = mode_q;

  p_strap_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sampled_q |=> mode_q == $past(strap_i));
  p_mode_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sampled_q |=> $stable(mode_q));
  p_reset_clear_r4: assert property (@(posedge clk_i)
    !rst_ni |-> !mode_q);
endmodule

// File: rtl/conn_nand_chain.sv
module conn_nand_chain #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] in_i,
  output logic         out_o
);
  logic [N-1:0] stage;

  // farthest stage uses its own input on both legs
  assign stage[N-1] = ~(in_i[N-1] & in_i[N-1]);

  for (genvar k = 0; k < N - 1; k++) begin : g_stage
    assign stage[k] = ~(in_i[k] & stage[k+1]);
  end

  assign out_o = stage[0];

  localparam logic ALL_HIGH_OUT = ((N % 2) == 0);

  always_comb begin
    if (in_i == '0) p_all_low_r7: assert (out_o == 1'b1);
    if (in_i == '1) p_all_high_r9: assert (out_o == ALL_HIGH_OUT);
  end
endmodule

// File: rtl/conn_pin_mux.sv
module conn_pin_mux (
  input  logic mode_i,
  input  logic tree_i,
  input  logic func_i,
  output logic pin_o
);
  always_comb begin
    pin_o = func_i;
    if (mode_i) pin_o = tree_i;
  end
endmodule

// File: rtl/conn_test_tree.sv
module conn_test_tree
  import conn_test_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_i,
  input  logic             sda_i,
  input  logic             scl_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic             func_i,
  output logic             pin_o,
  output logic             test_mode_o
);
  logic [TREE_W-1:0] tree_in;
  logic              tree_out;

  always_comb begin
    tree_in                       = '0;
    tree_in[POS_SDA]              = sda_i;
    tree_in[POS_SCL]              = scl_i;
    tree_in[POS_VID +: VID_W]     = vid_i;
  end

  conn_strap_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strap_i(strap_i),
    .mode_o (test_mode_o)
  );

  conn_nand_chain #(.N(TREE_W)) u_chain (
    .in_i (tree_in),
    .out_o(tree_out)
  );

  conn_pin_mux u_mux (
    .mode_i(test_mode_o),
    .tree_i(tree_out),
    .func_i(func_i),
    .pin_o (pin_o)
  );

  p_normal_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_o |-> pin_o == func_i);
  p_func_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_o && $stable(test_mode_o) && $stable(tree_in) |-> $stable(pin_o));
  p_reset_pass_r1: assert property (@(posedge clk_i)
    !rst_ni |-> pin_o == func_i);
endmodule

// File: tb/conn_test_tree_tb.sv
module conn_test_tree_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strap = 1'b0;
  logic       sda = 1'b0, scl = 1'b0, func = 1'b0;
  logic [3:0] vid = '0;
  logic       pin, tmode;

  int total = 0, bad = 0;
  bit m_sampled = 0, m_mode = 0;
  bit done = 0;

  always #4 clk = ~clk;

  conn_test_tree u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap), .sda_i(sda), .scl_i(scl),
    .vid_i(vid), .func_i(func), .pin_o(pin), .test_mode_o(tmode)
  );

  function automatic bit chain_ref(input bit [5:0] v);
    bit acc = 1'b1;
    for (int k = 5; k >= 0; k--) acc = !(v[k] && acc);
    return acc;
  endfunction

  function automatic bit [5:0] ins();
    return {vid, scl, sda};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference mode model
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sampled <= 0; m_mode <= 0;
    end else if (!m_sampled) begin
      m_sampled <= 1; m_mode <= strap;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (!done) begin
      bit exp_pin;
      exp_pin = m_mode ? chain_ref(ins()) : func;
      chk(tmode === m_mode, m_mode ? "R2 mode" : "R4 mode", tmode, m_mode);
      chk(pin === exp_pin, m_mode ? "R9 pin" : "R5 pin", pin, exp_pin);
    end
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    bit prev;
    // R1: reset state
    step(2);
    func = 1'b1; #1;
    chk(tmode === 1'b0, "R1 mode", tmode, 0);
    chk(pin === 1'b1, "R1 pin", pin, 1);
    func = 1'b0; #1;
    chk(pin === 1'b0, "R1 pin", pin, 0);

    // normal mode, strap low
    strap = 1'b0;
    rst_ni = 1'b1;
    step(2);
    chk(tmode === 1'b0, "R2 low strap", tmode, 0);
    strap = 1'b1;
    step(3);
    chk(tmode === 1'b0, "R3 strap ignored", tmode, 0);
    for (int i = 0; i < 20; i++) begin
      func = $urandom_range(0, 1);
      {vid, scl, sda} = 6'($urandom);
      #1;
      chk(pin === func, "R5 pass", pin, func);
      step(1);
    end

    // enter test mode
    @(negedge clk); rst_ni = 1'b0; strap = 1'b1;
    step(1);
    chk(tmode === 1'b0, "R4 reset clears", tmode, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(tmode === 1'b1, "R2 high strap", tmode, 1);
    #1; strap = 1'b0;
    step(3);
    chk(tmode === 1'b1, "R3 strap ignored", tmode, 1);

    // R7 and R8: walking one
    {vid, scl, sda} = '0; #1;
    chk(pin === 1'b1, "R7 all low", pin, 1);
    prev = pin;
    for (int k = 0; k < 6; k++) begin
      if (k == 0) sda = 1'b1;
      else if (k == 1) scl = 1'b1;
      else vid[k-2] = 1'b1;
      #1;
      chk(pin === !prev, "R8 toggle", pin, !prev);
      prev = pin;
      step(1);
    end
    chk(pin === 1'b1, "R9 all high", pin, 1);

    // R6: func has no effect
    for (int i = 0; i < 8; i++) begin
      func = ~func; #1;
      chk(pin === 1'b1, "R6 func blocked", pin, 1);
      step(1);
    end

    // R9: arbitrary patterns
    for (int i = 0; i < 64; i++) begin
      {vid, scl, sda} = 6'(i);
      func = $urandom_range(0, 1);
      #1;
      chk(pin === chain_ref(6'(i)), "R9 chain", pin, chain_ref(6'(i)));
      step(1);
    end

    // R4: reset asserted again clears mode at once
    @(negedge clk); #1; rst_ni = 1'b0; #1;
    chk(tmode === 1'b0, "R4 async clear", tmode, 0);
    chk(pin === func, "R1 pin in reset", pin, func);
    step(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule